// File: doc/BRIEF.md
# Compare-and-Toggle Timer Channel

This block is a single compare channel that sits beside a 16-bit free-running timebase. Each time the timebase steps onto the value held in the channel's 16-bit compare register, the channel raises a sticky event flag. The flag can drive an interrupt request. When the channel is configured for fast output, each of these events also inverts a dedicated output pin.

Software reaches the channel through a byte-wide register bus. The compare value is written as two bytes. A low-byte write disarms the comparator and a high-byte write re-arms it, so a full 16-bit update never matches against a half-written value. While the comparator is disarmed, the output pin holds its level.

Register addresses:

| Address | Contents |
|---|---|
| 0 | Compare low byte |
| 1 | Compare high byte |
| 2 | Mode register |
| 3 | Status: bit 0 is the flag |

Top module: `cmp_toggle_chan`

## Requirements
- R1: A match occurs on the rising clock edge where `run` is 1 and the timebase steps to a value equal to the compare register. A match sets the flag (status bit 0 at address 3) only when the mode bits `arm` (bit 3 at address 2) and `mat` (bit 2) are both 1.
- R2: In timer mode (`arm`=1, `mat`=1, `tgl` bit 1 = 0), a match sets the flag and leaves `tgl_out` unchanged.
- R3: `irq` is 1 exactly while the flag is 1 and the interrupt-enable bit (bit 0 at address 2) is 1.
- R4: The flag stays set until a bus write to address 3 with data bit 0 = 0. Writing 1 to that bit has no effect.
- R5: In fast-output mode (`arm`, `mat` and `tgl` all 1), `tgl_out` inverts on every match.
- R6: A write to address 0 forces `arm` to 0, and a write to address 1 forces `arm` to 1. While `arm` is 0, no match sets the flag or changes `tgl_out`.
- R7: After reset, `count` is 0x0000, the flag, `tgl_out` and `irq` are 0, every mode bit is 0, and the compare register is 0x0000.
- R8: The timebase advances by one on each clock where `run` is 1, holds its value otherwise, and wraps from 0xFFFF to 0x0000.
- R9: While `run` is 0, no match occurs, even when `count` already equals the compare register.
- R10: If a flag-clear write and a match happen in the same cycle, the flag ends up set.
- R11: With `mat`=0, a match sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| count | output | 16 | Timebase value |
| tgl_out | output | 1 | Toggle output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds the timebase on the compare value with `run` low. A design that compares levels instead of steps would set the flag again right after software cleared it. The bench also lands a clear write on the same edge as a match. Clear-wins priority would lose that event.

The bench writes only the low byte and then runs past the compare value, where a comparator that is not disarmed would toggle the pin. It also makes a full wrap of the timebase, which an overflow or width mistake would break. Finally, it writes 1 to the flag bit and checks with `mat` clear, to catch clear-on-any-write and ungated flag setting.

// File: rtl/cmp_toggle_chan.sv
module cmp_toggle_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic [1:0]   rd_addr,
  output logic [7:0]   rd_data,
  output logic [W-1:0] count,
  output logic         tgl_out,
  output logic         irq
);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_MODE = 2'd2, A_STAT = 2'd3;

  logic [W-1:0] cmp, count_nxt;
  logic arm, mat, tgl, ien, flag, hit, clr;

  assign count_nxt = count + 1'b1;
  assign hit = run && (count_nxt == cmp) && arm && mat;
  assign clr = wr_en && (wr_addr == A_STAT) && !wr_data[0];
  assign irq = flag && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      cmp     <= '0;
      {arm, mat, tgl, ien} <= 4'b0;
      flag    <= 1'b0;
      tgl_out <= 1'b0;
    end else begin
      if (run) count <= count_nxt;
      if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (hit && tgl) tgl_out <= !tgl_out;
      if (wr_en) begin
        case (wr_addr)
          A_LO:   begin cmp[7:0] <= wr_data; arm <= 1'b0; end
          A_HI:   begin cmp[W-1:8] <= wr_data[W-9:0]; arm <= 1'b1; end
          A_MODE: {arm, mat, tgl, ien} <= wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_LO:    rd_data = cmp[7:0];
      A_HI:    rd_data = cmp[W-1:8];
      A_MODE:  rd_data = {4'b0, arm, mat, tgl, ien};
      default: rd_data = {7'b0, flag};
    endcase
  end
endmodule

module cmp_toggle_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [7:0]   wr_data,
  input logic [W-1:0] count,
  input logic         flag,
  input logic         arm,
  input logic         mat,
  input logic         tgl,
  input logic         tgl_out,
  input logic         irq
);
  p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && wr_addr == 2'd3 && !wr_data[0]) |=> flag);
  p_toggle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm && mat && tgl) |=> $stable(tgl_out));
  p_lo_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd0 |=> !arm);
  p_hi_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd1 |=> arm);
  p_paused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
  p_no_set_paused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !flag |=> !flag);
endmodule

bind cmp_toggle_chan cmp_toggle_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .count(count), .flag(flag), .arm(arm), .mat(mat),
  .tgl(tgl), .tgl_out(tgl_out), .irq(irq));

// File: tb/tb_cmp_toggle_chan.sv
`timescale 1ns/1ps
module tb_cmp_toggle_chan;
  logic clk = 0, rst_n = 0, run = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] count;
  logic tgl_out, irq;

  always #2.5 clk = ~clk;

  cmp_toggle_chan dut (.clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .tgl_out(tgl_out), .irq(irq));

  typedef struct { string tag; logic [15:0] cnt; logic flag, out, irq; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  logic [15:0] mcnt = 0;
  logic done = 0;

  task automatic cyc(input bit r, input bit we, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    run = r; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    run = 0; wr_en = 0;
    if (r) mcnt = mcnt + 1'b1;
  endtask

  task automatic runs(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(0, 1, a, d);
  endtask

  task automatic expect_st(input string tag, input logic f, input logic o, input logic i);
    item_t it;
    it.tag = tag; it.cnt = mcnt; it.flag = f; it.out = o; it.irq = i;
    q.push_back(it);
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #0.5;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd[%0d] actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] sv;
      it = q.pop_front();
      rd_addr = 2'd3; #0.1; sv = rd_data;
      n_chk++;
      if (count !== it.cnt || sv[0] !== it.flag || tgl_out !== it.out || irq !== it.irq) begin
        n_bad++;
        $display("FAIL %s: actual cnt=%h flag=%b out=%b irq=%b expected cnt=%h flag=%b out=%b irq=%b",
          it.tag, count, sv[0], tgl_out, irq, it.cnt, it.flag, it.out, it.irq);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    expect_st("R7 reset", 0, 0, 0);
    @(posedge clk); #3;
    rd("R7 mode", 2, 8'h00);
    rd("R7 cmp lo", 0, 8'h00);
    rd("R7 cmp hi", 1, 8'h00);
    wr(0, 8'h05);
    rd("R6 lo disarms", 2, 8'h00);
    wr(1, 8'h00);
    rd("R6 hi arms", 2, 8'h08);
    wr(2, 8'h0D);
    runs(4);
    expect_st("R1 before match", 0, 0, 0);
    runs(1);
    expect_st("R1 R2 R3 timer match", 1, 0, 1);
    wr(3, 8'h01);
    expect_st("R4 write one", 1, 0, 1);
    wr(3, 8'h00);
    expect_st("R4 clear", 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 0);
    expect_st("R8 R9 paused on match value", 0, 0, 0);
    wr(2, 8'h09);
    wr(0, 8'h08); wr(1, 8'h00);
    runs(3);
    expect_st("R11 mat clear", 0, 0, 0);
    wr(2, 8'h0E);
    wr(0, 8'h10); wr(1, 8'h00);
    runs(8);
    expect_st("R5 R3 fast toggle", 1, 1, 0);
    wr(3, 8'h00);
    runs(65535);
    expect_st("R8 wrap", 0, 1, 0);
    runs(1);
    expect_st("R5 R8 second toggle", 1, 0, 0);
    wr(0, 8'h20);
    wr(3, 8'h00);
    runs(16);
    expect_st("R6 disarmed hold", 0, 0, 0);
    wr(0, 8'h30); wr(1, 8'h00);
    runs(16);
    expect_st("R6 rearmed toggle", 1, 1, 0);
    wr(3, 8'h00);
    expect_st("R4 clear again", 0, 1, 0);
    wr(0, 8'h40); wr(1, 8'h00);
    runs(15);
    cyc(1, 1, 3, 8'h00);
    expect_st("R10 match beats clear", 1, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule